// File: doc/BRIEF.md
# Per-Bit Access-Policy Status Register

This block is one 16-bit management register. Each bit has its own access policy, chosen by a parameter. A bit can be plain storage, a live status view, a sticky event flag cleared in one of several ways, a latching status cleared by a read, a one-cycle pulse or anti-pulse command, or a reserved hole. The surrounding register file decodes the address and drives `sel`. It then issues read and write strobes with write data, and takes the registered read data back. The functions in the chip that own the status conditions drive one hardware event or condition line per bit.

Two reset paths are provided. The hardware reset loads every bit from the reset-value parameter. The software reset does the same, except for the bits listed in a keep mask, which hold their contents. The current contents of all bits are also driven out on `cfg_q`, so that hardware can use stored configuration and command pulses directly.

Top module: `acc_policy_reg`

## Requirements
- R1: When `rst` is high, every bit of `cfg_q` takes its value from `RST_VAL` on the next clock edge, including bits in the `NASR` keep mask, and `rdata` becomes 0. Reserved bits always reset to 0.
- R2: The 4-bit field `POLICY[4*i+3:4*i]` selects the policy of bit i, with these codes: 0 read/write, 1 read-only, 2 write-only, 3 write-1-to-clear, 4 write-any-to-clear, 5 read-to-clear, 6 latch-high, 7 latch-low, 8 self-clearing, 9 self-setting, 10 reserved. A read/write bit takes `wdata[i]` on a selected write. A read-only bit shows the `hw_evt[i]` level of the previous cycle, and writes do not change it.
- R3: A selected read (`sel` and `rd_stb`) loads `rdata` on the next edge with the contents before that read's own clearing. Write-only and reserved bits read as 0. `rdata` holds its value when no selected read occurs.
- R4: A write-only bit stores `wdata[i]` on a selected write, shows the stored value on `cfg_q`, and reads as 0.
- R5: A write-1-to-clear bit is set by `hw_evt[i]`. A selected write with `wdata[i]=1` clears it, and a write with `wdata[i]=0` leaves it unchanged.
- R6: A write-any-to-clear bit is set by `hw_evt[i]`. Any selected write clears it, whatever the data. A read does not clear it.
- R7: A read-to-clear or latch-high bit is set by `hw_evt[i]` and stays set until a selected read. After that read it equals the `hw_evt[i]` level of the read cycle. Writes have no effect on it.
- R8: A latch-low bit resets to 1 in the default configuration. A low `hw_evt[i]` drives it to 0, and it stays 0 until a selected read. After that read it equals the `hw_evt[i]` level of the read cycle.
- R9: A self-clearing bit is 1 for exactly the one cycle after a selected write with `wdata[i]=1`, and 0 otherwise. A self-setting bit is 0 for exactly the one cycle after a selected write with `wdata[i]=0`, and 1 otherwise.
- R10: When a clearing access (a read, or a clearing write) and an active event or condition reach a sticky or latching bit in the same cycle, the event wins. The bit stays in its captured state.
- R11: With `sw_rst` high, every bit outside the `NASR` mask takes its `RST_VAL` value on the next edge. Bits in the mask keep their contents.
- R12: Strobes with `sel` low change no bit and do not update `rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| sw_rst | input | 1 | Synchronous software reset; spares bits in the keep mask |
| sel | input | 1 | Address match for this register |
| rd_stb | input | 1 | Read strobe |
| wr_stb | input | 1 | Write strobe |
| wdata | input | W | Write data |
| hw_evt | input | W | Per-bit hardware event or condition level |
| rdata | output | W | Registered read data |
| cfg_q | output | W | Current contents of every bit |

## Verification
The collision of interest is a clearing register access and a hardware event arriving on the same edge. It can be a read against a read-to-clear, latch-high or latch-low bit, or a clearing write against a write-1-to-clear or write-any-to-clear bit. The bench sweeps every combination of event level and clearing access on these bits. It judges the result on `cfg_q` one edge later, and judges `rdata` for the value before clearing. A second pairing covers software reset arriving together with kept and non-kept bits that hold values different from their reset values.

// File: rtl/acc_pkg.sv
package acc_pkg;
  localparam int ACC_PW = 4;

  typedef enum logic [ACC_PW-1:0] {
    ACC_RW  = 4'd0,
    ACC_RO  = 4'd1,
    ACC_WO  = 4'd2,
    ACC_W1C = 4'd3,
    ACC_WAC = 4'd4,
    ACC_RC  = 4'd5,
    ACC_LH  = 4'd6,
    ACC_LL  = 4'd7,
    ACC_SC  = 4'd8,
    ACC_SS  = 4'd9,
    ACC_RSV = 4'd10
  } acc_pol_e;
endpackage

// File: rtl/acc_bit_cell.sv
module acc_bit_cell
  import acc_pkg::*;
#(
  parameter logic [ACC_PW-1:0] POL   = ACC_RW,
  parameter logic              RST_V = 1'b0,
  parameter logic              KEEP  = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic sw_rst,
  input  logic wr,
  input  logic rd,
  input  logic wd,
  input  logic evt,
  output logic q
);
  localparam logic RV = (POL == ACC_RSV) ? 1'b0 : RST_V;

  logic nq;

  always_comb begin
    case (POL)
      ACC_RW, ACC_WO:  nq = wr ? wd : q;
      ACC_RO:          nq = evt;
      ACC_W1C:         nq = evt | (q & ~(wr & wd));
      ACC_WAC:         nq = evt | (q & ~wr);
      ACC_RC, ACC_LH:  nq = evt | (q & ~rd);
      ACC_LL:          nq = evt & (q | rd);
      ACC_SC:          nq = wr & wd;
      ACC_SS:          nq = ~(wr & ~wd);
      default:         nq = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= RV;
    end else if (sw_rst && !KEEP) begin
      q <= RV;
    end else begin
      q <= nq;
    end
  end
endmodule

// File: rtl/acc_rd_stage.sv
module acc_rd_stage #(
  parameter int          W       = 16,
  parameter logic [W-1:0] RD_MASK = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         rd,
  input  logic [W-1:0] q,
  output logic [W-1:0] rdata
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd) begin
      rdata <= q & RD_MASK;
    end
  end
endmodule

// File: rtl/acc_policy_reg.sv
module acc_policy_reg
  import acc_pkg::*;
#(
  parameter int                  W       = 16,
  parameter logic [ACC_PW*W-1:0] POLICY  = 64'hA103_0A98_7654_3210,
  parameter logic [W-1:0]        RST_VAL = 16'h0A80,
  parameter logic [W-1:0]        NASR    = 16'h1800
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sw_rst,
  input  logic         sel,
  input  logic         rd_stb,
  input  logic         wr_stb,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] hw_evt,
  output logic [W-1:0] rdata,
  output logic [W-1:0] cfg_q
);
  function automatic logic [W-1:0] read_mask();
    logic [W-1:0] m;
    for (int i = 0; i < W; i++) begin
      m[i] = !((POLICY[ACC_PW*i +: ACC_PW] == ACC_WO) ||
               (POLICY[ACC_PW*i +: ACC_PW] == ACC_RSV));
    end
    return m;
  endfunction

  localparam logic [W-1:0] RD_MASK = read_mask();

  logic         wr_hit;
  logic         rd_hit;
  logic [W-1:0] st;

  assign wr_hit = sel & wr_stb;
  assign rd_hit = sel & rd_stb;

  for (genvar i = 0; i < W; i++) begin : g_bit
    acc_bit_cell #(
      .POL   (POLICY[ACC_PW*i +: ACC_PW]),
      .RST_V (RST_VAL[i]),
      .KEEP  (NASR[i])
    ) u_cell (
      .clk    (clk),
      .rst    (rst),
      .sw_rst (sw_rst),
      .wr     (wr_hit),
      .rd     (rd_hit),
      .wd     (wdata[i]),
      .evt    (hw_evt[i]),
      .q      (st[i])
    );
  end

  acc_rd_stage #(
    .W       (W),
    .RD_MASK (RD_MASK)
  ) u_rd (
    .clk   (clk),
    .rst   (rst),
    .rd    (rd_hit),
    .q     (st),
    .rdata (rdata)
  );

  assign cfg_q = st;
endmodule

// File: rtl/acc_policy_reg_chk.sv
module acc_policy_reg_chk
  import acc_pkg::*;
#(
  parameter int                  W       = 16,
  parameter logic [ACC_PW*W-1:0] POLICY  = 64'hA103_0A98_7654_3210,
  parameter logic [W-1:0]        RST_VAL = 16'h0A80,
  parameter logic [W-1:0]        NASR    = 16'h1800
) (
  input logic         clk,
  input logic         rst,
  input logic         sw_rst,
  input logic         sel,
  input logic         rd_stb,
  input logic         wr_stb,
  input logic [W-1:0] wdata,
  input logic [W-1:0] hw_evt,
  input logic [W-1:0] rdata,
  input logic [W-1:0] cfg_q
);
  function automatic logic [W-1:0] pol_mask(input logic [ACC_PW-1:0] c);
    logic [W-1:0] m;
    for (int i = 0; i < W; i++) m[i] = (POLICY[ACC_PW*i +: ACC_PW] == c);
    return m;
  endfunction

  localparam logic [W-1:0] RSV_M = pol_mask(ACC_RSV);
  localparam logic [W-1:0] RD_M  = ~(pol_mask(ACC_WO) | RSV_M);
  localparam logic [W-1:0] SC_M  = pol_mask(ACC_SC);
  localparam logic [W-1:0] SS_M  = pol_mask(ACC_SS);
  localparam logic [W-1:0] STK_M = pol_mask(ACC_W1C) | pol_mask(ACC_WAC) |
                                   pol_mask(ACC_RC)  | pol_mask(ACC_LH);
  localparam logic [W-1:0] STO_M = pol_mask(ACC_RW) | pol_mask(ACC_WO);
  localparam logic [W-1:0] SWR_M = ~NASR;
  localparam logic [W-1:0] SWR_V = RST_VAL & ~NASR & ~RSV_M;

  logic [W-1:0] unused_wd;
  assign unused_wd = wdata;

  p_read_data_r3: assert property (@(posedge clk) disable iff (rst)
    (sel && rd_stb) |=> rdata == ($past(cfg_q) & RD_M));

  p_read_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !(sel && rd_stb) |=> $stable(rdata));

  p_sc_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    (!(sel && wr_stb) && !sw_rst) |=> (cfg_q & SC_M) == '0);

  p_ss_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    (!(sel && wr_stb) && !sw_rst) |=> (cfg_q & SS_M) == SS_M);

  p_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    (!sw_rst && !(sel && (rd_stb || wr_stb)))
      |=> (cfg_q & $past(cfg_q & STK_M)) == $past(cfg_q & STK_M));

  p_evt_wins_r10: assert property (@(posedge clk) disable iff (rst)
    !sw_rst |=> (cfg_q & $past(hw_evt & STK_M)) == $past(hw_evt & STK_M));

  p_sw_reset_r11: assert property (@(posedge clk) disable iff (rst)
    sw_rst |=> (cfg_q & SWR_M) == SWR_V);

  p_unsel_r12: assert property (@(posedge clk) disable iff (rst)
    (!sel && !sw_rst) |=> ((cfg_q ^ $past(cfg_q)) & STO_M) == '0);
endmodule

bind acc_policy_reg acc_policy_reg_chk #(
  .W       (W),
  .POLICY  (POLICY),
  .RST_VAL (RST_VAL),
  .NASR    (NASR)
) u_chk (.*);

// File: tb/test_acc_policy_reg.sv
`timescale 1ns/1ps
module test_acc_policy_reg;
  localparam logic [15:0] IDLE = 16'h0080;

  logic        clk = 1'b0;
  logic        rst, sw_rst, sel, rd_stb, wr_stb;
  logic [15:0] wdata, hw_evt, rdata, cfg_q;
  int          checks = 0;
  int          errors = 0;
  bit          done = 0;

  always #4 clk = ~clk;

  acc_policy_reg i_acc_policy_reg (
    .clk(clk), .rst(rst), .sw_rst(sw_rst), .sel(sel), .rd_stb(rd_stb),
    .wr_stb(wr_stb), .wdata(wdata), .hw_evt(hw_evt), .rdata(rdata),
    .cfg_q(cfg_q)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic s, input logic r, input logic w,
                      input logic [15:0] d, input logic [15:0] e, input logic sr);
    sel = s; rd_stb = r; wr_stb = w; wdata = d; hw_evt = e; sw_rst = sr;
    @(posedge clk);
    @(negedge clk);
    sel = 0; rd_stb = 0; wr_stb = 0; wdata = '0; hw_evt = IDLE; sw_rst = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst = 1; sw_rst = 0; sel = 0; rd_stb = 0; wr_stb = 0; wdata = '0; hw_evt = IDLE;
    @(negedge clk);
    step(0, 0, 0, 16'h0, IDLE, 0);
    chk("R1 reset contents", cfg_q, 16'h0A80);
    chk("R1 reset rdata", rdata, 16'h0000);
    rst = 0;
    step(0, 0, 0, 16'h0, IDLE, 0);

    // write all ones: RW, WO, SC, SS take it; RO, sticky and reserved do not
    step(1, 0, 1, 16'hFFFF, IDLE, 0);
    chk("R2 R4 R9 write all ones", cfg_q, 16'h2B85);
    step(0, 0, 0, 16'h0, IDLE, 0);
    chk("R9 self-clear after one cycle", cfg_q, 16'h2A85);
    step(0, 0, 1, 16'h0000, IDLE, 0);
    chk("R12 unselected write", cfg_q, 16'h2A85);
    step(0, 1, 0, 16'h0, IDLE, 0);
    chk("R12 unselected read rdata", rdata, 16'h0000);

    // read-only follows the condition, ignores writes
    step(0, 0, 0, 16'h0, IDLE | 16'h4002, 0);
    chk("R2 read-only tracks event", cfg_q, 16'h6A87);
    step(1, 0, 1, 16'h0000, IDLE | 16'h4002, 0);
    chk("R2 R9 write zeros", cfg_q, 16'h4082);
    step(0, 0, 0, 16'h0, IDLE, 0);
    chk("R9 self-set restores", cfg_q, 16'h0280);

    // read path with write-only masked
    step(1, 0, 1, 16'h2205, IDLE, 0);
    chk("R4 write-only stored", cfg_q, 16'h2285);
    step(1, 1, 0, 16'h0, IDLE, 0);
    chk("R3 R4 read data masks write-only", rdata, 16'h2281);
    step(0, 0, 0, 16'h0, IDLE, 0);
    chk("R3 rdata held", rdata, 16'h2281);

    // write-1-to-clear sweep over event and data
    for (int e = 0; e < 2; e++) begin
      for (int d = 0; d < 2; d++) begin
        step(0, 0, 0, 16'h0, IDLE | 16'h1008, 0);
        step(1, 0, 1, d ? 16'h1008 : 16'h0, IDLE | (e ? 16'h1008 : 16'h0), 0);
        chk(e ? "R5 R10 w1c with event" : "R5 w1c", cfg_q & 16'h1008,
            (e != 0 || d == 0) ? 16'h1008 : 16'h0000);
      end
    end
    step(1, 0, 1, 16'h1008, IDLE, 0);
    chk("R5 w1c cleared", cfg_q & 16'h1008, 16'h0000);

    // write-anything-to-clear
    step(0, 0, 0, 16'h0, IDLE | 16'h0010, 0);
    chk("R6 wac set", cfg_q & 16'h0010, 16'h0010);
    step(1, 1, 0, 16'h0, IDLE, 0);
    chk("R6 wac not cleared by read", cfg_q & 16'h0010, 16'h0010);
    step(1, 0, 1, 16'h0000, IDLE, 0);
    chk("R6 wac cleared by zero write", cfg_q & 16'h0010, 16'h0000);
    step(0, 0, 0, 16'h0, IDLE | 16'h0010, 0);
    step(1, 0, 1, 16'h0000, IDLE | 16'h0010, 0);
    chk("R10 wac event beats write", cfg_q & 16'h0010, 16'h0010);
    step(1, 0, 1, 16'h0000, IDLE, 0);

    // read-to-clear and latch-high sweep
    for (int e = 0; e < 2; e++) begin
      step(0, 0, 0, 16'h0, IDLE | 16'h0060, 0);
      step(0, 0, 0, 16'h0, IDLE, 0);
      chk("R7 latched after event gone", cfg_q & 16'h0060, 16'h0060);
      step(1, 1, 0, 16'h0, IDLE | (e ? 16'h0060 : 16'h0), 0);
      chk("R3 R7 read returns latched", rdata & 16'h0060, 16'h0060);
      chk(e ? "R10 read with event" : "R7 read clears", cfg_q & 16'h0060,
          e ? 16'h0060 : 16'h0000);
    end
    step(1, 0, 1, 16'h0060, IDLE, 0);
    chk("R7 write ignored", cfg_q & 16'h0060, 16'h0060);
    step(0, 1, 0, 16'h0, IDLE, 0);
    chk("R12 unselected read keeps latch", cfg_q & 16'h0060, 16'h0060);
    step(1, 1, 0, 16'h0, IDLE, 0);
    chk("R7 cleared", cfg_q & 16'h0060, 16'h0000);

    // latch-low
    step(0, 0, 0, 16'h0, 16'h0000, 0);
    step(0, 0, 0, 16'h0, IDLE, 0);
    chk("R8 low captured", cfg_q & 16'h0080, 16'h0000);
    step(1, 1, 0, 16'h0, IDLE, 0);
    chk("R8 read shows low", rdata & 16'h0080, 16'h0000);
    chk("R8 released after read", cfg_q & 16'h0080, 16'h0080);
    step(0, 0, 0, 16'h0, 16'h0000, 0);
    step(1, 1, 0, 16'h0, 16'h0000, 0);
    chk("R10 low during read stays", cfg_q & 16'h0080, 16'h0000);
    step(1, 1, 0, 16'h0, IDLE, 0);
    chk("R8 released", cfg_q & 16'h0080, 16'h0080);

    // software reset with kept bits
    step(1, 0, 1, 16'h0201, IDLE, 0);
    step(0, 0, 0, 16'h0, 16'h1008, 0);
    chk("R11 before soft reset", cfg_q & 16'h1889, 16'h1009);
    step(0, 0, 0, 16'h0, IDLE, 1);
    chk("R11 soft reset keeps masked", cfg_q & 16'h1889, 16'h1080);

    rst = 1;
    step(0, 0, 0, 16'h0, IDLE, 0);
    rst = 0;
    chk("R1 hard reset overrides keep", cfg_q, 16'h0A80);
    chk("R1 hard reset rdata", rdata, 16'h0000);

    // read/write storage sweep
    for (int k = 0; k < 8; k++) begin
      logic [15:0] v;
      v = (k[2] ? 16'h2000 : 16'h0) | (k[1] ? 16'h0800 : 16'h0) | (k[0] ? 16'h0001 : 16'h0);
      step(1, 0, 1, v | 16'h0200, IDLE, 0);
      chk("R2 rw store", cfg_q & 16'h2801, v);
      step(1, 1, 0, 16'h0, IDLE, 0);
      chk("R3 rw readback", rdata & 16'h2801, v);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule